// File: doc/BRIEF.md
# Coin-Pulse Vending Controller with Registered Open Output

This block counts coin value toward a fixed price and raises an open signal once the price has been reached. Coins arrive as single-cycle pulses. There is one pulse input for a five-unit coin and one for a ten-unit coin. A two-bit credit register tracks progress. The encodings are 0, 5, 10 and "15 or more".

The state update uses fixed sum-of-products equations. The open signal comes straight from its own flip-flop. That flip-flop is loaded on every clock with the AND of the two next-state bits. As a result, no gate sits between any register and the output pin, and the output cannot glitch.

A build option can instead select the plain decoded form, where open is the AND of the present state bits. Both forms give the same cycle behaviour at the ports. The credit register is brought out so that a user can see the progress toward the price.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous reset clears the credit register and the open output. Both read zero at the first sample after a reset edge.
- R2: The credit register is output as `level_o`, with bit 1 = Q1 and bit 0 = Q0. On each clock, Q1 becomes Q1 | dime | (Q0 & nickel).
- R3: On each clock, Q0 becomes (~Q0 & nickel) | (Q0 & ~nickel) | (Q1 & nickel) | (Q1 & dime).
- R4: In every cycle outside reset, `open_o` equals `level_o[1] & level_o[0]`. The output is produced directly by a flip-flop.
- R5: Once `level_o` is 3, it stays 3 and `open_o` stays high under any coin input until the next reset.
- R6: When both pulses arrive in the same cycle, the equations of R2 and R3 apply as written. Levels 0 and 2 go to 3, and level 1 goes to 2.
- R7: In a cycle with no coin pulse, `level_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_n | input | 1 | One-cycle pulse for a five-unit coin |
| coin_d | input | 1 | One-cycle pulse for a ten-unit coin |
| level_o | output | 2 | Current credit code: 0, 5, 10, or 15 and above |
| open_o | output | 1 | Registered open indication |

## Verification
The assertions take the coin inputs to be valid and settled at each rising edge. Each pulse is assumed to be a clean single-cycle event. The assertions do not treat a simultaneous pulse on both inputs as illegal. Instead, they check that the equations still apply in that case.

The stimulus changes inputs only at falling edges and holds each pulse for exactly one cycle. It also walks every reachable credit level against all four input combinations, including the simultaneous one.

// File: rtl/vend_pkg.sv
package vend_pkg;
   localparam int STATE_W = 2;
   typedef logic [STATE_W-1:0] vend_state_t;

   localparam vend_state_t LVL_ZERO = 2'b00;
   localparam vend_state_t LVL_FIVE = 2'b01;
   localparam vend_state_t LVL_TEN  = 2'b10;
   localparam vend_state_t LVL_FULL = 2'b11;

   // High state bit: latches on any dime, or on a nickel at five.
   function automatic logic hi_next(input vend_state_t s, input logic nk, input logic dm);
      return s[1] | dm | (s[0] & nk);
   endfunction

   // Low state bit: toggles on a nickel, forced high once the high bit is set
   // and any coin arrives.
   function automatic logic lo_next(input vend_state_t s, input logic nk, input logic dm);
      return (~s[0] & nk) | (s[0] & ~nk) | (s[1] & nk) | (s[1] & dm);
   endfunction
endpackage

// File: rtl/vend_next_state.sv
module vend_next_state
   import vend_pkg::*;
(
   input  vend_state_t cur,
   input  logic        nickel,
   input  logic        dime,
   output vend_state_t nxt
);
   always_comb begin
      nxt    = LVL_ZERO;
      nxt[1] = hi_next(cur, nickel, dime);
      nxt[0] = lo_next(cur, nickel, dime);
   end
endmodule

// File: rtl/vend_sreg.sv
module vend_sreg #(
   parameter int              WIDTH     = 2,
   parameter logic [WIDTH-1:0] RST_VALUE = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("vend_sreg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VALUE;
      else     q <= d;
   end
endmodule

// File: rtl/vend_open_out.sv
module vend_open_out
   import vend_pkg::*;
#(
   parameter int OPEN_MODE = 1
) (
   input  logic        clk,
   input  logic        rst,
   input  vend_state_t cur,
   input  vend_state_t nxt,
   output logic        open_o
);
   if (OPEN_MODE != 0 && OPEN_MODE != 1) begin : g_bad_mode
      $error("vend_open_out: OPEN_MODE must be 0 or 1");
   end

   if (OPEN_MODE == 1) begin : g_retimed
      logic open_d;
      logic open_q;
      assign open_d = nxt[1] & nxt[0];
      vend_sreg #(.WIDTH(1), .RST_VALUE(1'b0)) u_open_reg (
         .clk (clk),
         .rst (rst),
         .d   (open_d),
         .q   (open_q)
      );
      assign open_o = open_q;
   end else begin : g_decoded
      assign open_o = cur[1] & cur[0];
   end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
   import vend_pkg::*;
#(
   parameter int OPEN_MODE = 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       coin_n,
   input  logic       coin_d,
   output logic [1:0] level_o,
   output logic       open_o
);
   vend_state_t cur_s;
   vend_state_t nxt_s;

   vend_next_state u_next (
      .cur    (cur_s),
      .nickel (coin_n),
      .dime   (coin_d),
      .nxt    (nxt_s)
   );

   vend_sreg #(.WIDTH(STATE_W), .RST_VALUE(LVL_ZERO)) u_state (
      .clk (clk),
      .rst (rst),
      .d   (nxt_s),
      .q   (cur_s)
   );

   vend_open_out #(.OPEN_MODE(OPEN_MODE)) u_open (
      .clk    (clk),
      .rst    (rst),
      .cur    (cur_s),
      .nxt    (nxt_s),
      .open_o (open_o)
   );

   assign level_o = cur_s;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic       coin_n,
   input logic       coin_d,
   input logic [1:0] level,
   input logic       open_o
);
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (level == 2'd0 && !open_o));

   assert_hi_bit_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> level[1] == ($past(level[1]) | $past(coin_d) | ($past(level[0]) & $past(coin_n))));

   assert_lo_bit_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> level[0] == ((~$past(level[0]) & $past(coin_n)) | ($past(level[0]) & ~$past(coin_n))
                                   | ($past(level[1]) & $past(coin_n)) | ($past(level[1]) & $past(coin_d))));

   assert_open_follows_R4: assert property (@(posedge clk) disable iff (rst)
      open_o == (level[1] & level[0]));

   assert_full_sticks_R5: assert property (@(posedge clk) disable iff (rst)
      (level == 2'd3) |=> (level == 2'd3 && open_o));

   assert_both_at_five_R6: assert property (@(posedge clk) disable iff (rst)
      (coin_n && coin_d && level == 2'd1) |=> (level == 2'd2));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!coin_n && !coin_d) |=> $stable(level));
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .coin_n (coin_n),
   .coin_d (coin_d),
   .level  (level_o),
   .open_o (open_o)
);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       coin_n = 1'b0;
   logic       coin_d = 1'b0;
   logic [1:0] level_o;
   logic       open_o;
   int         tests = 0;
   int         fails = 0;
   bit         mon_en = 1'b0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   vend_ctrl dut (
      .clk     (clk),
      .rst     (rst),
      .coin_n  (coin_n),
      .coin_d  (coin_d),
      .level_o (level_o),
      .open_o  (open_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Bench is parked at a falling edge when each task starts.
   task automatic do_reset();
      rst = 1'b1;
      @(negedge clk);
      chk("R1 level after reset", int'(level_o), 0);
      chk("R1 open after reset", int'(open_o), 0);
      rst = 1'b0;
   endtask

   task automatic pulse(input logic n, input logic d);
      coin_n = n;
      coin_d = d;
      @(negedge clk);
      coin_n = 1'b0;
      coin_d = 1'b0;
   endtask

   task automatic reach(input int lvl);
      case (lvl)
         1: pulse(1'b1, 1'b0);
         2: pulse(1'b0, 1'b1);
         3: begin pulse(1'b0, 1'b1); pulse(1'b1, 1'b0); end
         default: ;
      endcase
   endtask

   // R4 checked on every cycle outside reset.
   always @(negedge clk) begin
      if (mon_en && !rst)
         chk("R4 open vs level", int'(open_o), int'(level_o[1] & level_o[0]));
   end

   initial begin
      int exp;
      repeat (3) @(negedge clk);
      chk("R1 level held in reset", int'(level_o), 0);
      chk("R1 open held in reset", int'(open_o), 0);
      rst = 1'b0;
      mon_en = 1'b1;

      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 4; c++) begin
            do_reset();
            reach(s);
            chk("R2 R3 setup level", int'(level_o), s);
            if (c == 3) begin
               // R6: both pulses together, equations applied as written
               exp = (s == 1) ? 2 : 3;
            end else begin
               exp = s + ((c & 1) != 0 ? 1 : 0) + ((c & 2) != 0 ? 2 : 0);
               if (exp > 3) exp = 3;
            end
            pulse(c[0], c[1]);
            chk(c == 3 ? "R6 both coins high bit" : "R2 high bit", int'(level_o[1]), (exp >> 1) & 1);
            chk(c == 3 ? "R6 both coins low bit" : "R3 low bit", int'(level_o[0]), exp & 1);
            chk("R4 open after coin", int'(open_o), exp == 3 ? 1 : 0);
            pulse(1'b0, 1'b0);
            chk("R7 idle hold", int'(level_o), exp);
         end
      end

      do_reset();
      reach(3);
      for (int i = 0; i < 16; i++) begin
         pulse(i % 3 == 1, i % 3 == 2);
         chk("R5 full level sticks", int'(level_o), 3);
         chk("R5 open stays high", int'(open_o), 1);
      end
      do_reset();
      chk("R1 reset leaves full", int'(level_o), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule